// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

This peripheral combines a 16-bit free-running divider with an 8-bit programmable counter. The divider advances on every cycle in which the input-rate enable is high. Software sees the divider's upper byte as a read-only value, and any write to it clears the whole divider.

A control register picks one of four divider rates and gates the counter. On each selected period the counter advances by one. When it would pass 0xFF, it loads a software-set modulo value instead of wrapping to zero. In that same cycle it raises a single-cycle interrupt request. The CPU reaches all four registers through a byte-wide port with one shared address for reads and writes. Reads are combinational and writes take effect at the next clock edge.

Top module: `prog_timer`

## Requirements
- R1: After synchronous reset, the divider, counter, modulo and control registers all read 0 and the interrupt output is low.
- R2: The divider advances by one at each clock edge where `tick_en_i` is high and holds otherwise. Reading address 0 returns divider bits 15:8.
- R3: A write of any value to address 0 clears all 16 divider bits. In that cycle the counter receives no advance.
- R4: Control bit 2 (address 3) enables the counter. While it is 0, the counter (address 1) holds its value whatever `tick_en_i` does.
- R5: Control bits 1:0 select the counter period in enabled ticks: 0 selects 1024, 1 selects 16, 2 selects 64 and 3 selects 256. Counting starts from a cleared divider, so the first advance comes on the N-th tick.
- R6: When an advance finds the counter at 0xFF, the counter loads the modulo register (address 2) instead of wrapping.
- R7: Each reload drives `irq_o` high for exactly one cycle. That is the cycle in which the counter first shows the reloaded value.
- R8: A CPU write to address 1 in the same cycle as an overflow wins. The counter takes the written byte and no interrupt is raised.
- R9: Addresses are 0 for the divider, 1 for the counter, 2 for the modulo and 3 for control. The modulo reads back as written, and control reads back bits 2:0 with bits 7:3 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Input-rate enable; one divider step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Single-cycle timer interrupt request |

## Verification
Two events can meet in one cycle: a counter overflow reload and a CPU write to the counter register. The bench sets the counter to 0xFF and brings the divider to one tick short of the selected period. It then raises the tick enable and the counter write together in a single cycle. Afterwards it checks that the counter holds the written byte rather than the modulo, and that the interrupt stays low both in that cycle and in the next.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int unsigned DIV_W  = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned N_RATE = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIV = 2'd0,
        SEL_CNT = 2'd1,
        SEL_MOD = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       run;
        logic [1:0] rate;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    // log2 of the counter period, in enabled ticks, for each rate code
    function automatic int unsigned rate_log2(input int unsigned code);
        case (code)
            0:       return 10;
            1:       return 4;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/ptimer_divider.sv
module ptimer_divider #(
    parameter int unsigned DIV_W = ptimer_pkg::DIV_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [DIV_W-1:0] div_o
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign div_o = div_q;

    p_div_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (div_q == '0));

    p_div_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !clr_i) |=> (div_q == $past(div_q) + DIV_W'(1)));

    p_div_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !clr_i) |=> $stable(div_q));

endmodule

// File: rtl/ptimer_rate.sv
module ptimer_rate #(
    parameter int unsigned DIV_W  = ptimer_pkg::DIV_W,
    parameter int unsigned N_RATE = ptimer_pkg::N_RATE
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [DIV_W-1:0]          div_i,
    input  logic                      tick_i,
    input  logic                      clr_i,
    input  logic                      run_i,
    input  logic [$clog2(N_RATE)-1:0] rate_i,
    output logic                      inc_o
);

    logic [N_RATE-1:0] at_end;

    // one period detector per rate code: low bits all ones means the
    // next tick completes a period
    for (genvar g = 0; g < N_RATE; g++) begin : g_tap
        localparam int unsigned LOG2 = ptimer_pkg::rate_log2(g);
        assign at_end[g] = &div_i[LOG2-1:0];
    end

    assign inc_o = tick_i && run_i && !clr_i && at_end[rate_i];

    // every period is a multiple of 16 ticks
    p_inc_aligned_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        inc_o |-> (div_i[3:0] == 4'hF));

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
    parameter int unsigned DATA_W = ptimer_pkg::DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              inc_i,
    input  logic              wr_cnt_i,
    input  logic              wr_mod_i,
    input  logic              wr_ctl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] mod_o,
    output ptimer_pkg::ctl_t  ctl_o,
    output logic              irq_o
);

    import ptimer_pkg::*;

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] mod_q;
    ctl_t              ctl_q;
    logic              irq_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            mod_q <= '0;
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_cnt_i) begin
                cnt_q <= wdata_i;
            end else if (inc_i) begin
                if (cnt_q == '1) begin
                    cnt_q <= mod_q;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + DATA_W'(1);
                end
            end
            if (wr_mod_i) mod_q <= wdata_i;
            if (wr_ctl_i) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
        end
    end

    assign cnt_o = cnt_q;
    assign mod_o = mod_q;
    assign ctl_o = ctl_q;
    assign irq_o = irq_q;

    p_hold_disabled_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctl_q.run && !wr_cnt_i) |=> $stable(cnt_q));

    p_reload_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_q |-> (cnt_q == $past(mod_q)));

    p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_q |=> !irq_q);

    p_wr_wins_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_cnt_i |=> ((cnt_q == $past(wdata_i)) && !irq_q));

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int unsigned DIV_W  = ptimer_pkg::DIV_W,
    parameter int unsigned DATA_W = ptimer_pkg::DATA_W,
    parameter int unsigned ADDR_W = ptimer_pkg::ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    import ptimer_pkg::*;

    reg_sel_e          sel;
    logic              wr_div, wr_cnt, wr_mod, wr_ctl;
    logic [DIV_W-1:0]  div;
    logic              inc;
    logic [DATA_W-1:0] cnt, modv;
    ctl_t              ctl;

    assign sel    = reg_sel_e'(addr_i);
    assign wr_div = wr_en_i && (sel == SEL_DIV);
    assign wr_cnt = wr_en_i && (sel == SEL_CNT);
    assign wr_mod = wr_en_i && (sel == SEL_MOD);
    assign wr_ctl = wr_en_i && (sel == SEL_CTL);

    ptimer_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_en_i),
        .clr_i  (wr_div),
        .div_o  (div)
    );

    ptimer_rate #(.DIV_W(DIV_W), .N_RATE(N_RATE)) u_rate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .div_i  (div),
        .tick_i (tick_en_i),
        .clr_i  (wr_div),
        .run_i  (ctl.run),
        .rate_i (ctl.rate),
        .inc_o  (inc)
    );

    ptimer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .inc_i    (inc),
        .wr_cnt_i (wr_cnt),
        .wr_mod_i (wr_mod),
        .wr_ctl_i (wr_ctl),
        .wdata_i  (wdata_i),
        .cnt_o    (cnt),
        .mod_o    (modv),
        .ctl_o    (ctl),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_DIV: rdata_o = div[DIV_W-1 -: DATA_W];
            SEL_CNT: rdata_o = cnt;
            SEL_MOD: rdata_o = modv;
            default: rdata_o = DATA_W'(ctl);
        endcase
    end

endmodule

// File: tb/prog_timer_test.sv
module prog_timer_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    prog_timer uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .tick_en_i (tick_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #0.5;
        v = int'(rdata);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_divider;
        int v;
        wr(2'd0, 8'h00);
        ticks(256);
        rd(2'd0, v); chk("R2 div 256", v, 8'h01);
        ticks(16'h1234 - 256);
        rd(2'd0, v); chk("R2 div 1234", v, 8'h12);
        repeat (300) @(negedge clk);
        rd(2'd0, v); chk("R2 div hold", v, 8'h12);
        wr(2'd0, 8'hAB);
        rd(2'd0, v); chk("R3 div cleared", v, 8'h00);
        ticks(255);
        rd(2'd0, v); chk("R3 low bits cleared", v, 8'h00);
        ticks(1);
        rd(2'd0, v); chk("R3 first carry", v, 8'h01);
    endtask

    task automatic t_regs;
        int v;
        wr(2'd2, 8'h5A);
        rd(2'd2, v); chk("R9 modulo readback", v, 8'h5A);
        wr(2'd3, 8'hF8);
        rd(2'd3, v); chk("R9 control readback", v, 8'h00);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R9 control upper zero", v, 8'h07);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_rate(input int code, input int period);
        int v;
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'(4 | code));
        wr(2'd0, 8'h00);
        ticks(period - 1);
        rd(2'd1, v); chk("R5 before period", v, 0);
        ticks(1);
        rd(2'd1, v); chk("R5 first advance", v, 1);
        ticks(period);
        rd(2'd1, v); chk("R5 second advance", v, 2);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_enable;
        int v;
        wr(2'd3, 8'h01);
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h00);
        ticks(64);
        rd(2'd1, v); chk("R4 disabled hold", v, 5);
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h00);
        ticks(16);
        rd(2'd1, v); chk("R4 enabled advance", v, 6);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_overflow;
        int v;
        wr(2'd2, 8'hF0);
        wr(2'd1, 8'hFE);
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h00);
        ticks(31);
        rd(2'd1, v); chk("R6 at FF", v, 8'hFF);
        chk("R7 irq idle", int'(irq), 0);
        tick_en = 1'b1;
        @(negedge clk);
        rd(2'd1, v);
        chk("R6 reload value", v, 8'hF0);
        chk("R7 irq high", int'(irq), 1);
        tick_en = 1'b0;
        @(negedge clk);
        chk("R7 irq one cycle", int'(irq), 0);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_collide;
        int v;
        wr(2'd2, 8'h30);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h00);
        ticks(15);
        tick_en = 1'b1;
        addr    = 2'd1;
        wdata   = 8'h77;
        wr_en   = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        wr_en   = 1'b0;
        rd(2'd1, v);
        chk("R8 write wins", v, 8'h77);
        chk("R8 no irq", int'(irq), 0);
        @(negedge clk);
        chk("R8 no irq later", int'(irq), 0);
        rd(2'd1, v); chk("R8 value kept", v, 8'h77);
        wr(2'd3, 8'h00);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        tick_en = 1'b0;
        wr_en   = 1'b0;
        addr    = 2'd0;
        wdata   = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_divider();
        t_regs();
        t_rate(1, 16);
        t_rate(2, 64);
        t_rate(3, 256);
        t_rate(0, 1024);
        t_enable();
        t_overflow();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule